// File: doc/BRIEF.md
# Frame-Count Locked DTO Clock

This block generates output pixel-clock enables from a phase accumulator that runs on a fast system clock. It keeps those enables in step with incoming video without a phase detector. The decoder's recovered clock jitters too much to drive a PLL, so the block looks only at whole frames. Between two successive frame-start pulses it counts the ticks it has produced. It then compares that count with the number a nominal frame should hold and moves the accumulator increment in the direction that closes the gap.

The nominal raster is 864 pixels by 405 lines, so a frame holds 349920 pixel ticks. The `os_mode` input selects the counted clock. The preferred setting counts the oversampling tick at four times the pixel rate, which makes the target 1399680 per frame. Software-free configuration inputs set the nominal increment, the clamp limits, the loop gain (a right shift) and the lock tolerance. A timeout flag reports that frame starts have stopped arriving, and a lock flag reports that the loop has settled.

Top module: `frame_lock_dto`

## Requirements
- R1: Every clock the accumulator adds `coef` modulo 2^ACC_W. `os_tick` is high for one clock after each carry, so its long-run rate is coef/2^ACC_W ticks per clock.
- R2: `pix_tick` is high together with the OSR-th, 2·OSR-th, … `os_tick` counted since reset, and never without `os_tick`.
- R3: For each valid frame, with error = count − target: the increment drops by (error >>> `cfg_shift`), using floor for negative errors. A positive error whose shifted value is 0 still drops it by 1, and a zero error leaves it unchanged. The new value appears two clocks after the clock on which `frame_sof` is sampled.
- R4: `coef` changes only on a valid frame. The first frame-start after reset, or after a timeout, only arms the measurement and leaves `coef` as it was.
- R5: With `os_mode`=1 the count uses `os_tick` and the target is PIX_PER_LINE·LINES·OSR. With `os_mode`=0 it uses `pix_tick` and the target is PIX_PER_LINE·LINES. A frame's count is the selected ticks sampled on the clocks after the previous `frame_sof` clock, up to and including the current one.
- R6: After an update, `coef` lies within [`cfg_min`, `cfg_max`]. A result outside that range is clamped to the nearest limit.
- R7: `locked` goes high after LOCK_FRAMES consecutive valid frames with |error| ≤ `cfg_tol`. Any valid frame outside the tolerance clears it.
- R8: If the selected tick count since the last `frame_sof` reaches 2·target, `timeout` rises on the next clock. While it is high, `locked` is cleared and `coef` holds. The next `frame_sof` clears it and re-arms the measurement.
- R9: During reset `coef` equals `cfg_nominal`, and `os_tick`, `pix_tick`, `locked` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sof | input | 1 | One-clock reference frame-start pulse |
| os_mode | input | 1 | 1: count oversampling ticks; 0: count pixel ticks |
| cfg_nominal | input | ACC_W | Increment loaded at reset |
| cfg_min | input | ACC_W | Lower clamp for the increment |
| cfg_max | input | ACC_W | Upper clamp for the increment |
| cfg_shift | input | SHIFT_W | Loop gain as a right shift of the error |
| cfg_tol | input | CNT_W | Largest absolute error counted as in lock |
| os_tick | output | 1 | Oversampling tick enable |
| pix_tick | output | 1 | Pixel tick enable |
| coef | output | ACC_W | Current accumulator increment |
| locked | output | 1 | Loop settled |
| timeout | output | 1 | No frame-start within two frames of ticks |

## Verification
The inline properties check the relationships that hold on every clock. A pixel tick never appears without an oversampling tick. The increment stays constant except after a measurement. Each correction moves the increment in the right direction and ends inside the clamp limits. A rejected frame or a timeout always leaves the loop unlocked, a timeout persists until the next frame start, and a measurement is never reported while timed out. The exact size of each correction, the discarded arming frame, the tick rate, the choice of counted clock, lock acquisition and the timeout threshold can only be shown by the bench's scenarios. There, a model of the requirements follows random frame lengths and gain settings alongside directed short, long, clamped and missing-frame cases.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
   typedef enum logic {
      SEL_PIXEL     = 1'b0,
      SEL_OVERSAMPLE = 1'b1
   } tick_sel_e;

   function automatic int frame_target(input int ppl, input int lines, input int osr, input tick_sel_e sel);
      return (sel == SEL_OVERSAMPLE) ? ppl * lines * osr : ppl * lines;
   endfunction
endpackage

// File: rtl/dto_accum.sv
module dto_accum #(
   parameter int ACC_W = 32,
   parameter int OSR   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] coef,
   output logic             os_tick,
   output logic             pix_tick
);
   localparam int PH_W = (OSR > 1) ? $clog2(OSR) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

   initial begin : elab_checks
      assert (ACC_W >= 8) else $error("dto_accum: ACC_W too small");
      assert (OSR >= 2) else $error("dto_accum: OSR must be at least 2");
   end

   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] acc;
   logic [PH_W-1:0]  phase;
   logic [PH_W-1:0]  phase_nxt;
   logic             carry;

   assign sum   = {1'b0, acc} + {1'b0, coef};
   assign carry = sum[ACC_W];

   generate
      if ((OSR & (OSR - 1)) == 0) begin : g_pow2
         assign phase_nxt = phase + PH_W'(1);
      end else begin : g_mod
         assign phase_nxt = (phase == PH_LAST) ? '0 : phase + PH_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         phase    <= '0;
         os_tick  <= 1'b0;
         pix_tick <= 1'b0;
      end else begin
         acc      <= sum[ACC_W-1:0];
         os_tick  <= carry;
         pix_tick <= carry && (phase == PH_LAST);
         if (carry) phase <= phase_nxt;
      end
   end

   p_pix_on_os_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_tick |-> os_tick);
endmodule

// File: rtl/frame_tick_counter.sv
module frame_tick_counter #(
   parameter int CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             sel_tick,
   input  logic [CNT_W-1:0] target,
   output logic             meas_valid,
   output logic [CNT_W-1:0] meas,
   output logic             timeout
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] limit;
   logic             armed;

   assign cnt_inc = cnt + CNT_W'(sel_tick);
   assign limit   = target << 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         meas       <= '0;
         meas_valid <= 1'b0;
         armed      <= 1'b0;
         timeout    <= 1'b0;
      end else begin
         meas_valid <= 1'b0;
         if (sof) begin
            meas       <= cnt_inc;
            meas_valid <= armed && !timeout;
            cnt        <= '0;
            armed      <= 1'b1;
            timeout    <= 1'b0;
         end else if (!timeout) begin
            cnt <= cnt_inc;
            if (cnt_inc >= limit) timeout <= 1'b1;
         end
      end
   end

   p_no_meas_in_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !meas_valid);
   p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !sof) |=> timeout);
endmodule

// File: rtl/coef_ctrl.sv
module coef_ctrl #(
   parameter int ACC_W       = 32,
   parameter int CNT_W       = 22,
   parameter int SHIFT_W     = 5,
   parameter int LOCK_FRAMES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ACC_W-1:0]   cfg_nominal,
   input  logic [ACC_W-1:0]   cfg_min,
   input  logic [ACC_W-1:0]   cfg_max,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic [CNT_W-1:0]   cfg_tol,
   input  logic [CNT_W-1:0]   target,
   input  logic               meas_valid,
   input  logic [CNT_W-1:0]   meas,
   input  logic               timeout,
   output logic [ACC_W-1:0]   coef,
   output logic               locked
);
   localparam int EW   = CNT_W + 1;
   localparam int MW   = ((ACC_W > EW) ? ACC_W : EW) + 2;
   localparam int SC_W = $clog2(LOCK_FRAMES + 1);
   localparam logic [SC_W-1:0] SC_FULL = SC_W'(LOCK_FRAMES);

   initial begin : elab_checks
      assert (LOCK_FRAMES >= 1) else $error("coef_ctrl: LOCK_FRAMES must be positive");
   end

   logic signed [EW-1:0] err;
   logic signed [EW-1:0] shifted;
   logic signed [EW-1:0] step;
   logic        [EW-1:0] mag;
   logic                 good;
   logic signed [MW-1:0] cand, min_e, max_e;
   logic [ACC_W-1:0]     coef_nxt;
   logic [SC_W-1:0]      streak, streak_nxt;

   assign err     = $signed({1'b0, meas}) - $signed({1'b0, target});
   assign shifted = err >>> cfg_shift;
   assign step    = (!err[EW-1] && (err != '0) && (shifted == '0)) ? EW'(1) : shifted;
   assign mag     = err[EW-1] ? EW'(-err) : EW'(err);
   assign good    = mag <= {1'b0, cfg_tol};

   assign min_e = $signed({{(MW-ACC_W){1'b0}}, cfg_min});
   assign max_e = $signed({{(MW-ACC_W){1'b0}}, cfg_max});
   assign cand  = $signed({{(MW-ACC_W){1'b0}}, coef}) - $signed({{(MW-EW){step[EW-1]}}, step});

   always_comb begin
      if (cand < min_e)      coef_nxt = cfg_min;
      else if (cand > max_e) coef_nxt = cfg_max;
      else                   coef_nxt = cand[ACC_W-1:0];
   end

   assign streak_nxt = (streak == SC_FULL) ? streak : streak + SC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef   <= cfg_nominal;
         streak <= '0;
         locked <= 1'b0;
      end else if (timeout) begin
         streak <= '0;
         locked <= 1'b0;
      end else if (meas_valid) begin
         coef <= coef_nxt;
         if (good) begin
            streak <= streak_nxt;
            locked <= (streak_nxt == SC_FULL);
         end else begin
            streak <= '0;
            locked <= 1'b0;
         end
      end
   end

   p_hold_between_frames_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_valid |=> $stable(coef));
   p_slow_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !timeout && (meas > target)) |=> (coef <= $past(coef)));
   p_speed_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !timeout && (meas < target)) |=> (coef >= $past(coef)));
   p_in_limits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !timeout) |=> ((coef >= cfg_min) && (coef <= cfg_max)));
   p_bad_frame_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !good) |=> !locked);
   p_timeout_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !locked);
endmodule

// File: rtl/frame_lock_dto.sv
module frame_lock_dto
   import frame_lock_pkg::*;
#(
   parameter int ACC_W        = 32,
   parameter int PIX_PER_LINE = 864,
   parameter int LINES        = 405,
   parameter int OSR          = 4,
   parameter int LOCK_FRAMES  = 4,
   parameter int SHIFT_W      = 5,
   parameter int CNT_W        = $clog2(2 * PIX_PER_LINE * LINES * OSR + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_sof,
   input  logic               os_mode,
   input  logic [ACC_W-1:0]   cfg_nominal,
   input  logic [ACC_W-1:0]   cfg_min,
   input  logic [ACC_W-1:0]   cfg_max,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic [CNT_W-1:0]   cfg_tol,
   output logic               os_tick,
   output logic               pix_tick,
   output logic [ACC_W-1:0]   coef,
   output logic               locked,
   output logic               timeout
);
   localparam int TGT_PIX = frame_target(PIX_PER_LINE, LINES, OSR, SEL_PIXEL);
   localparam int TGT_OS  = frame_target(PIX_PER_LINE, LINES, OSR, SEL_OVERSAMPLE);

   initial begin : elab_checks
      assert (longint'(2 * TGT_OS) < (longint'(1) << CNT_W))
         else $error("frame_lock_dto: CNT_W cannot hold two frames of ticks");
   end

   tick_sel_e        sel;
   logic             sel_tick;
   logic [CNT_W-1:0] target;
   logic             meas_valid;
   logic [CNT_W-1:0] meas;

   assign sel      = tick_sel_e'(os_mode);
   assign sel_tick = (sel == SEL_OVERSAMPLE) ? os_tick : pix_tick;
   assign target   = (sel == SEL_OVERSAMPLE) ? CNT_W'(TGT_OS) : CNT_W'(TGT_PIX);

   dto_accum #(.ACC_W(ACC_W), .OSR(OSR)) u_dto (
      .clk      (clk),
      .rst_n    (rst_n),
      .coef     (coef),
      .os_tick  (os_tick),
      .pix_tick (pix_tick)
   );

   frame_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof        (frame_sof),
      .sel_tick   (sel_tick),
      .target     (target),
      .meas_valid (meas_valid),
      .meas       (meas),
      .timeout    (timeout)
   );

   coef_ctrl #(
      .ACC_W(ACC_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .LOCK_FRAMES(LOCK_FRAMES)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_nominal (cfg_nominal),
      .cfg_min     (cfg_min),
      .cfg_max     (cfg_max),
      .cfg_shift   (cfg_shift),
      .cfg_tol     (cfg_tol),
      .target      (target),
      .meas_valid  (meas_valid),
      .meas        (meas),
      .timeout     (timeout),
      .coef        (coef),
      .locked      (locked)
   );
endmodule

// File: tb/frame_lock_dto_tb.sv
`timescale 1ns/1ps
module frame_lock_dto_tb;
   localparam int ACC_W = 12;
   localparam int PPL   = 8;
   localparam int LNS   = 4;
   localparam int OSR   = 4;
   localparam int LOCKN = 4;
   localparam int SHW   = 5;
   localparam int CNT_W = $clog2(2 * PPL * LNS * OSR + 2);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_sof = 1'b0;
   logic             os_mode = 1'b1;
   logic [ACC_W-1:0] cfg_nominal = 12'd1024;
   logic [ACC_W-1:0] cfg_min = 12'd256;
   logic [ACC_W-1:0] cfg_max = 12'd3000;
   logic [SHW-1:0]   cfg_shift = '0;
   logic [CNT_W-1:0] cfg_tol = CNT_W'(4);
   logic             os_tick, pix_tick, locked, timeout;
   logic [ACC_W-1:0] coef;

   frame_lock_dto #(
      .ACC_W(ACC_W), .PIX_PER_LINE(PPL), .LINES(LNS), .OSR(OSR),
      .LOCK_FRAMES(LOCKN), .SHIFT_W(SHW), .CNT_W(CNT_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_sof(frame_sof), .os_mode(os_mode),
      .cfg_nominal(cfg_nominal), .cfg_min(cfg_min), .cfg_max(cfg_max),
      .cfg_shift(cfg_shift), .cfg_tol(cfg_tol),
      .os_tick(os_tick), .pix_tick(pix_tick), .coef(coef),
      .locked(locked), .timeout(timeout)
   );

   always #2.5 clk = ~clk;

   int     n_chk = 0;
   int     n_fail = 0;
   bit     done = 1'b0;
   longint os_total, pix_total, acc_sel, exp_coef;
   bit     exp_armed, exp_to, exp_locked, pend_valid;
   int     streak, pend;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint tgt();
      return os_mode ? PPL * LNS * OSR : PPL * LNS;
   endfunction

   function automatic longint model_coef(input longint c, input longint err, input int sh);
      longint st = err >>> sh;
      if (err > 0 && st == 0) st = 1;
      c = c - st;
      if (c < longint'(cfg_min)) c = cfg_min;
      if (c > longint'(cfg_max)) c = cfg_max;
      return c;
   endfunction

   task automatic cyc(input bit s);
      @(negedge clk);
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            if (pend_valid) check(coef == exp_coef, "R3", "coef after frame", coef, exp_coef);
            else            check(coef == exp_coef, "R4", "coef after arming sof", coef, exp_coef);
            check(locked == exp_locked, "R7", "locked", locked, exp_locked);
            check(pix_total == os_total / OSR, "R2", "pixel tick total", pix_total, os_total / OSR);
         end
      end
      check(timeout == exp_to, "R8", "timeout flag", timeout, exp_to);
      if (pix_tick && !os_tick) check(1'b0, "R2", "pix without os", 1, 0);
      if (os_tick) os_total++;
      if (pix_tick) pix_total++;
      acc_sel += os_mode ? os_tick : pix_tick;
      frame_sof = s;
      if (s) begin
         pend_valid = exp_armed && !exp_to;
         if (pend_valid) begin
            longint err = acc_sel - tgt();
            exp_coef = model_coef(exp_coef, err, int'(cfg_shift));
            if ((err < 0 ? -err : err) <= longint'(cfg_tol)) begin
               if (streak < LOCKN) streak++;
            end else streak = 0;
            exp_locked = (streak == LOCKN);
         end
         pend = 2;
         exp_armed = 1'b1;
         exp_to = 1'b0;
         acc_sel = 0;
      end else if (!exp_to && acc_sel >= 2 * tgt()) begin
         exp_to = 1'b1;
         streak = 0;
         exp_locked = 1'b0;
      end
   endtask

   task automatic frame(input int len);
      for (int i = 0; i < len - 1; i++) cyc(1'b0);
      cyc(1'b1);
   endtask

   task automatic do_reset(input bit mode, input int nom, input int mn, input int mx);
      @(negedge clk);
      rst_n = 1'b0;
      frame_sof = 1'b0;
      os_mode = mode;
      cfg_nominal = ACC_W'(nom);
      cfg_min = ACC_W'(mn);
      cfg_max = ACC_W'(mx);
      repeat (3) @(negedge clk);
      check(coef == cfg_nominal, "R9", "coef in reset", coef, cfg_nominal);
      check(!os_tick && !pix_tick, "R9", "ticks in reset", os_tick, 0);
      check(!locked && !timeout, "R9", "flags in reset", {locked, timeout}, 0);
      rst_n = 1'b1;
      os_total = 0; pix_total = 0; acc_sel = 0; exp_coef = nom;
      exp_armed = 0; exp_to = 0; exp_locked = 0; streak = 0; pend = 0; pend_valid = 0;
   endtask

   initial begin
      longint held;
      void'($urandom(32'h1f2e3d4c));
      cfg_shift = '0; cfg_tol = CNT_W'(4);
      do_reset(1'b1, 1024, 256, 3000);

      // R1: rate at fixed increment 1024/4096 over 800 clocks
      for (int i = 0; i < 800; i++) cyc(1'b0);
      check(os_total >= 199 && os_total <= 201, "R1", "oversample tick rate", os_total, 200);
      check(pix_total == os_total / OSR, "R2", "pixel ticks from reset", pix_total, os_total / OSR);

      // R4: first sof only arms
      cyc(1'b1);
      cyc(1'b0); cyc(1'b0);
      check(coef == 1024, "R4", "no correction on arming frame", coef, 1024);

      // R7: nominal frames reach lock
      for (int f = 0; f < 6; f++) frame(512);
      repeat (3) cyc(1'b0);
      check(locked == 1'b1, "R7", "lock after steady frames", locked, 1);

      // R3/R7: short frame raises coef and drops lock
      held = coef;
      cfg_shift = SHW'(2);
      frame(300);
      repeat (3) cyc(1'b0);
      check(coef > held, "R3", "short frame raises coef", coef, held + 1);
      check(locked == 1'b0, "R7", "lock lost on bad frame", locked, 0);

      // R3: long frame lowers coef
      held = coef;
      frame(700);
      repeat (3) cyc(1'b0);
      check(coef < held, "R3", "long frame lowers coef", coef, held - 1);

      // R8: missing frame starts
      for (int i = 0; i < 1200; i++) cyc(1'b0);
      held = coef;
      for (int i = 0; i < 300; i++) cyc(1'b0);
      check(timeout == 1'b1, "R8", "timeout raised", timeout, 1);
      check(locked == 1'b0, "R8", "unlocked in timeout", locked, 0);
      check(coef == held, "R8", "coef held in timeout", coef, held);
      cyc(1'b1);
      repeat (3) cyc(1'b0);
      check(coef == held && timeout == 1'b0, "R8", "sof after timeout discarded", coef, held);
      frame(512);
      repeat (3) cyc(1'b0);

      // R6: upper clamp
      cfg_shift = '0;
      do_reset(1'b1, 1024, 512, 1030);
      frame(400); frame(400);
      repeat (3) cyc(1'b0);
      check(coef == 1030, "R6", "clamped at max", coef, 1030);
      // R6: lower clamp
      do_reset(1'b1, 1024, 1020, 2000);
      frame(700); frame(700);
      repeat (3) cyc(1'b0);
      check(coef == 1020, "R6", "clamped at min", coef, 1020);

      // R5: pixel-tick counting
      do_reset(1'b0, 1024, 256, 3000);
      frame(512); frame(512); frame(300); frame(600);
      repeat (3) cyc(1'b0);
      check(coef == exp_coef, "R5", "pixel mode correction", coef, exp_coef);

      // random frames and gains
      do_reset(1'b1, 1024, 700, 1300);
      cfg_tol = CNT_W'(3);
      for (int f = 0; f < 40; f++) begin
         repeat (4) cyc(1'b0);
         cfg_shift = SHW'($urandom % 4);
         frame(380 + int'($urandom % 300));
      end
      repeat (3) cyc(1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule